// File: doc/BRIEF.md
# PCI configuration access bridge

This block sits on the host memory bus and gives a processor a path into PCI configuration space through two 4 KB windows. Any access to the address window reads or writes a single 32-bit configuration address register. An access to the data window becomes one configuration read or write on a simple request/acknowledge port on the downstream side. The bus outside the block decodes the two windows and passes in a window select and the three low offset bits. Both windows are little-endian.

Before a request is issued, the latched address register is rewritten into the standard bus/device/function/register layout. The rewrite depends on bits 31 and 0 of the register. If bit 31 is set, the register passes through unchanged. If bit 31 is clear and bit 0 is set, the register already holds the standard layout. If both bits are clear, the register uses a one-hot select in which one bit among 31..11 names the device.

The processor access is held by a ready handshake until the downstream port acknowledges. Only one transaction is in flight at a time. A one-hot address with no select bit set never reaches the downstream port: the bridge completes the access itself as a master abort.

Top module: `cfg_access_bridge`

## Requirements
- R1: After reset the address register reads zero, and both `cfg_req` and `cpu_ready` are low.
- R2: A write to the address window stores all 32 bits of `cpu_wdata`. A later address-window read returns exactly that value. Each address-window access completes with `cpu_ready` one cycle after the request is seen.
- R3: With register bit 31 set, the downstream address is the register value ORed with `cpu_off[1:0]`.
- R4: With bit 31 clear and bit 0 set, the downstream address is register bits 31..3 followed by `cpu_off[2:0]`.
- R5: With bits 31 and 0 both clear, the downstream address is built as follows. Bits 31..16 are zero. Bits 15..11 hold the index (0 to 20) of the lowest set bit among register bits 31..11, counted from bit 11. Bits 10..8 come from register bits 10..8. Bits 7..3 come from register bits 7..3. Bits 2..0 come from `cpu_off[2:0]`.
- R6: A data-window access forwards `cpu_len` (1, 2 or 4 bytes), the write flag and `cpu_wdata` to the downstream port unchanged.
- R7: A data-window read returns `cfg_rdata` as it was in the acknowledge cycle.
- R8: `cfg_req` stays high, with stable address and length, until `cfg_ack`. `cpu_ready` pulses for one cycle, one cycle after the acknowledge. A request with acknowledge delay d therefore completes d+2 cycles after it is presented. No second downstream request is issued while one is open.
- R9: In the one-hot form with no bit set among register bits 31..11, no downstream request is made. A read returns 0xFFFFFFFF and a write is dropped. Either access completes one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Host access request, held until `cpu_ready` |
| cpu_sel_data | input | 1 | 0 = address window, 1 = data window |
| cpu_we | input | 1 | 1 = write |
| cpu_off | input | 3 | Low offset bits within the window |
| cpu_len | input | 3 | Access size in bytes: 1, 2 or 4 |
| cpu_wdata | input | 32 | Host write data |
| cpu_rdata | output | 32 | Host read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cfg_req | output | 1 | Downstream configuration request |
| cfg_we | output | 1 | Downstream write flag |
| cfg_addr | output | 32 | Converted configuration address |
| cfg_len | output | 3 | Downstream access size |
| cfg_wdata | output | 32 | Downstream write data |
| cfg_ack | input | 1 | Downstream acknowledge |
| cfg_rdata | input | 32 | Downstream read data, valid with `cfg_ack` |

## Verification
The hardest case to reach is the lowest-bit priority of the one-hot device select. In that case two or more select bits are set and the register bits below bit 11 are also populated. The bench loads such a value through the address window. It then checks that the lower set bit wins and that the function and register fields pass through untouched. The master abort path is only visible as an absence of any downstream request. The responder therefore counts every request it sees, and the bench compares that count before and after the access.

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_sel_data,
  input  logic        cpu_we,
  input  logic [2:0]  cpu_off,
  input  logic [2:0]  cpu_len,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_ready,
  output logic        cfg_req,
  output logic        cfg_we,
  output logic [31:0] cfg_addr,
  output logic [2:0]  cfg_len,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_ack,
  input  logic [31:0] cfg_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} state_t;
  state_t      state;
  logic [31:0] areg;
  logic [31:0] conv;
  logic [4:0]  dev_idx;
  logic        dev_hit;
  logic        abort;

  always_comb begin
    dev_idx = '0;
    dev_hit = 1'b0;
    for (int i = 20; i >= 0; i--) begin
      if (areg[11+i]) begin
        dev_idx = i[4:0];
        dev_hit = 1'b1;
      end
    end
  end

  always_comb begin
    if (areg[31])     conv = areg | {30'b0, cpu_off[1:0]};
    else if (areg[0]) conv = {areg[31:3], cpu_off};
    else              conv = {16'b0, dev_idx, areg[10:8], areg[7:3], cpu_off};
  end

  assign abort     = !areg[31] && !areg[0] && !dev_hit;
  assign cpu_ready = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      areg      <= '0;
      cpu_rdata <= '0;
      cfg_req   <= 1'b0;
      cfg_we    <= 1'b0;
      cfg_addr  <= '0;
      cfg_len   <= '0;
      cfg_wdata <= '0;
    end else begin
      case (state)
        S_IDLE: if (cpu_req) begin
          if (!cpu_sel_data) begin
            if (cpu_we) areg <= cpu_wdata;
            cpu_rdata <= areg;
            state     <= S_DONE;
          end else if (abort) begin
            cpu_rdata <= '1;
            state     <= S_DONE;
          end else begin
            cfg_req   <= 1'b1;
            cfg_we    <= cpu_we;
            cfg_addr  <= conv;
            cfg_len   <= cpu_len;
            cfg_wdata <= cpu_wdata;
            state     <= S_BUSY;
          end
        end
        S_BUSY: if (cfg_ack) begin
          cfg_req   <= 1'b0;
          cpu_rdata <= cfg_rdata;
          state     <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module cfg_access_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_ready,
  input logic        cfg_req,
  input logic        cfg_ack,
  input logic [31:0] cfg_addr,
  input logic [2:0]  cfg_len
);
  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> cfg_req && $stable(cfg_addr) && $stable(cfg_len));
  a_r8_ack_completes: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_ack |=> !cfg_req && cpu_ready);
  a_r8_no_early_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> !cpu_ready);
  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  a_r6_legal_len: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (cfg_len == 3'd1 || cfg_len == 3'd2 || cfg_len == 3'd4));
endmodule

bind cfg_access_bridge cfg_access_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .cfg_req(cfg_req),
  .cfg_ack(cfg_ack), .cfg_addr(cfg_addr), .cfg_len(cfg_len));

// File: tb/sim_cfg_access_bridge.sv
`timescale 1ns/1ps
module sim_cfg_access_bridge;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_sel_data = 0, cpu_we = 0;
  logic [2:0] cpu_off = 0, cpu_len = 4;
  logic [31:0] cpu_wdata = 0, cpu_rdata;
  logic cpu_ready, cfg_req, cfg_we, cfg_ack = 0;
  logic [31:0] cfg_addr, cfg_wdata, cfg_rdata = 0;
  logic [2:0] cfg_len;

  int tests = 0, fails = 0;
  int rsp_delay = 0, rsp_cnt = 0, nreq = 0;
  logic [31:0] got_addr, got_wdata, rsp_data = 32'h0;
  logic [2:0] got_len;
  logic got_we;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_access_bridge u0 (.*);

  initial begin
    forever begin
      @(negedge clk);
      if (cfg_ack) cfg_ack = 1'b0;
      else if (cfg_req) begin
        if (rsp_cnt == rsp_delay) begin
          cfg_ack = 1'b1; cfg_rdata = rsp_data;
          got_addr = cfg_addr; got_len = cfg_len; got_we = cfg_we; got_wdata = cfg_wdata;
          nreq++; rsp_cnt = 0;
        end else rsp_cnt++;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic win, input logic we, input logic [2:0] off,
                        input logic [2:0] len, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cpu_sel_data = win; cpu_we = we; cpu_off = off; cpu_len = len; cpu_wdata = wd;
    cpu_req = 1'b1; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!cpu_ready);
    rd = cpu_rdata; cpu_req = 1'b0;
  endtask

  task automatic set_areg(logic [31:0] v);
    logic [31:0] rd; int c;
    access(1'b0, 1'b1, 3'd0, 3'd4, v, rd, c);
  endtask

  task automatic t_reset;
    logic [31:0] rd; int c;
    check("R1 cfg_req", {31'b0, cfg_req}, 32'd0);
    check("R1 cpu_ready", {31'b0, cpu_ready}, 32'd0);
    access(1'b0, 1'b0, 3'd0, 3'd4, 32'h0, rd, c);
    check("R1 areg reset", rd, 32'h0);
  endtask

  task automatic t_areg;
    logic [31:0] rd; int c;
    access(1'b0, 1'b1, 3'd4, 3'd4, 32'hA5C3_0F19, rd, c);
    check("R2 write latency", c, 1);
    access(1'b0, 1'b0, 3'd0, 3'd4, 32'h0, rd, c);
    check("R2 readback", rd, 32'hA5C3_0F19);
    check("R2 read latency", c, 1);
  endtask

  task automatic t_pass;
    logic [31:0] rd; int c;
    rsp_delay = 0;
    set_areg(32'h8000_0C10);
    access(1'b1, 1'b0, 3'd7, 3'd1, 32'h0, rd, c);
    check("R3 pass-through or", got_addr, 32'h8000_0C13);
    set_areg(32'h8000_0C12);
    access(1'b1, 1'b0, 3'd1, 3'd1, 32'h0, rd, c);
    check("R3 or keeps bits", got_addr, 32'h8000_0C13);
  endtask

  task automatic t_cfa1;
    logic [31:0] rd; int c;
    set_areg(32'h0012_3A05);
    access(1'b1, 1'b0, 3'd6, 3'd2, 32'h0, rd, c);
    check("R4 low bits replaced", got_addr, 32'h0012_3A06);
  endtask

  task automatic t_cfa0;
    logic [31:0] rd; int c;
    set_areg(32'h0011_0348);
    access(1'b1, 1'b0, 3'd2, 3'd4, 32'h0, rd, c);
    check("R5 lowest select wins", got_addr, 32'h0000_2B4A);
    set_areg(32'h4000_0000);
    access(1'b1, 1'b0, 3'd0, 3'd4, 32'h0, rd, c);
    check("R5 top select bit", got_addr, 32'h0000_9800);
  endtask

  task automatic t_fwd;
    logic [31:0] rd; int c;
    set_areg(32'h0000_0801);
    access(1'b1, 1'b1, 3'd3, 3'd1, 32'h0000_00EE, rd, c);
    check("R6 byte len", {29'b0, got_len}, 32'd1);
    check("R6 write flag", {31'b0, got_we}, 32'd1);
    check("R6 wdata", got_wdata, 32'h0000_00EE);
    access(1'b1, 1'b0, 3'd2, 3'd2, 32'h0, rd, c);
    check("R6 half len", {29'b0, got_len}, 32'd2);
    check("R6 read flag", {31'b0, got_we}, 32'd0);
  endtask

  task automatic t_read;
    logic [31:0] rd; int c;
    rsp_data = 32'h1234_ABCD;
    access(1'b1, 1'b0, 3'd0, 3'd4, 32'h0, rd, c);
    check("R7 read data", rd, 32'h1234_ABCD);
  endtask

  task automatic t_wait;
    logic [31:0] rd; int c, n0;
    rsp_delay = 3; n0 = nreq;
    access(1'b1, 1'b0, 3'd0, 3'd4, 32'h0, rd, c);
    check("R8 latency d=3", c, 5);
    check("R8 single request", nreq - n0, 1);
    rsp_delay = 0;
    access(1'b1, 1'b0, 3'd0, 3'd4, 32'h0, rd, c);
    check("R8 latency d=0", c, 2);
  endtask

  task automatic t_abort;
    logic [31:0] rd; int c, n0;
    set_areg(32'h0000_07F8);
    n0 = nreq;
    access(1'b1, 1'b0, 3'd0, 3'd4, 32'h0, rd, c);
    check("R9 read all ones", rd, 32'hFFFF_FFFF);
    check("R9 read latency", c, 1);
    access(1'b1, 1'b1, 3'd0, 3'd4, 32'h5555_5555, rd, c);
    repeat (4) @(negedge clk);
    check("R9 no downstream", nreq - n0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_areg; t_pass; t_cfa1; t_cfa0; t_fwd; t_read; t_wait; t_abort;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule